// File: doc/BRIEF.md
# USB Line-State Monitor

The block watches the two single-ended USB data line levels. It turns each sampled pair into a bus state code: single-ended zero, J, K, or an illegal code for both lines high. Which of J and K is the idle level depends on a speed select input. A single duration counter measures how long the classified state has held without a change. From that count the block derives these outputs:

- an idle level;
- a resume level, for a K held long enough;
- a bus-reset level, for a long single-ended zero;
- connect and disconnect pulses, together with an attached status level.

For a port that faces downstream, a parameter adds a driver. When started, it asks the pad to hold both lines low for a fixed number of milliseconds, then reports completion with a one-cycle pulse. The clock frequency is a parameter, and all time limits are derived from it in cycles. The 2.5 µs limit is rounded up to whole cycles.

Top module: `usb_line_mon`

## Requirements
- R1: `line_state_o` encodes the lines sampled one clock earlier. 2'b00 is SE0 (both low) and 2'b11 is illegal (both high). 2'b01 is J and 2'b10 is K. With `full_speed_i`=1, J is D+ high / D- low. With `full_speed_i`=0, J is D- high / D+ low. K is the other mixed pair.
- R2: `idle_o`, `resume_o`, `bus_reset_o`, `connect_o` and `disconnect_o` do not assert until a state has held for at least THR_CYC = ceil(2.5 µs × CLK_HZ) cycles. They assert within THR_CYC+6 cycles of the lines being applied.
- R3: J held past the limit while detached gives a single one-cycle `connect_o` pulse, and `attached_o` goes high with it.
- R4: SE0 held past the limit while attached gives a single one-cycle `disconnect_o` pulse, and `attached_o` goes low with it.
- R5: While attached, a J that returns and holds again produces no further `connect_o` pulse, and `attached_o` stays high.
- R6: `bus_reset_o` is high exactly while `line_state_o` is SE0 and SE0 has held past the limit. It drops in the cycle the state code leaves SE0.
- R7: `resume_o` is high while K has held past the limit, and only while `line_state_o` is K.
- R8: A single cycle of the illegal state restarts the duration count. SE0 held for fewer than THR_CYC cycles after that cycle gives no `bus_reset_o`.
- R9: Changing `full_speed_i` reclassifies the lines in the next cycle and restarts the count. A held J becomes K, so `idle_o` drops and `resume_o` appears only after the limit again.
- R10: A `rst_start_i` pulse sets `drive_se0_o` one cycle later. `drive_se0_o` stays high for exactly RST_MS × CLK_HZ / 1000 cycles. `drive_done_o` pulses for one cycle when it falls.
- R11: `rst_start_i` is ignored while `drive_se0_o` is high, so the drive length does not change.
- R12: While `rst_ni` is low, these outputs are 0: `line_state_o` (which reads as SE0), `attached_o`, `connect_o`, `disconnect_o`, `drive_se0_o` and `drive_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | free-running clock of CLK_HZ |
| rst_ni | input | 1 | asynchronous reset, active low |
| dp_i | input | 1 | D+ line level |
| dm_i | input | 1 | D- line level |
| full_speed_i | input | 1 | 1 = full-speed line polarity, 0 = low-speed |
| rst_start_i | input | 1 | start driving a downstream reset |
| line_state_o | output | 2 | classified bus state code |
| idle_o | output | 1 | J held past the limit |
| resume_o | output | 1 | K held past the limit |
| bus_reset_o | output | 1 | SE0 held past the limit |
| connect_o | output | 1 | connect event pulse |
| disconnect_o | output | 1 | disconnect event pulse |
| attached_o | output | 1 | device attached status |
| drive_se0_o | output | 1 | request to hold both lines low |
| drive_done_o | output | 1 | pulse at the end of the driven reset |

## Verification
The hardest case to reach is a timer restart that leaves no trace in the state code. The bench does this in two ways. It breaks a run of SE0 with a single illegal cycle and then holds SE0 for a span that would already be long enough if the count had carried on. It also flips the speed select under steady lines, so that J turns into K without any line moving. In both cases the bench checks that the long-state outputs stay low until a full fresh window has passed.

// File: rtl/usb_lsm_pkg.sv
package usb_lsm_pkg;
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_BAD = 2'b11
  } line_e;

  function automatic line_e line_decode(input logic dp, input logic dm, input logic fs);
    case ({dp, dm})
      2'b00:   return LN_SE0;
      2'b11:   return LN_BAD;
      2'b10:   return fs ? LN_J : LN_K;
      default: return fs ? LN_K : LN_J;
    endcase
  endfunction
endpackage

// File: rtl/usb_lsm_classify.sv
module usb_lsm_classify
  import usb_lsm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  dp_i,
  input  logic  dm_i,
  input  logic  full_speed_i,
  output line_e state_o
);
  line_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LN_SE0;
    else         state_q <= line_decode(dp_i, dm_i, full_speed_i);
  end

  assign state_o = state_q;
endmodule

// File: rtl/usb_lsm_timer.sv
module usb_lsm_timer
  import usb_lsm_pkg::*;
#(
  parameter int unsigned CNT_MAX = 120
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  line_e state_i,
  output logic  held_o
);
  localparam int unsigned CW = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] CMAX = CW'(CNT_MAX);

  line_e         prev_q;
  logic [CW-1:0] cnt_q;
  logic          same;

  assign same = (state_i == prev_q) && (state_i != LN_BAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= LN_SE0;
      cnt_q  <= '0;
    end else begin
      prev_q <= state_i;
      if (!same)             cnt_q <= '0;
      else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign held_o = same && (cnt_q == CMAX);
endmodule

// File: rtl/usb_lsm_events.sv
module usb_lsm_events
  import usb_lsm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  line_e state_i,
  input  logic  held_i,
  output logic  idle_o,
  output logic  resume_o,
  output logic  bus_reset_o,
  output logic  connect_o,
  output logic  disconnect_o,
  output logic  attached_o
);
  logic conn_q, disc_q, att_q;
  logic long_j, long_se0;

  assign long_j   = held_i && (state_i == LN_J);
  assign long_se0 = held_i && (state_i == LN_SE0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q <= 1'b0;
      disc_q <= 1'b0;
      att_q  <= 1'b0;
    end else begin
      conn_q <= long_j && !att_q;
      disc_q <= long_se0 && att_q;
      if (long_j && !att_q)        att_q <= 1'b1;
      else if (long_se0 && att_q)  att_q <= 1'b0;
    end
  end

  assign idle_o       = long_j;
  assign resume_o     = held_i && (state_i == LN_K);
  assign bus_reset_o  = long_se0;
  assign connect_o    = conn_q;
  assign disconnect_o = disc_q;
  assign attached_o   = att_q;
endmodule

// File: rtl/usb_lsm_rstdrv.sv
module usb_lsm_rstdrv #(
  parameter int unsigned DRV_CYC = 480000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic drive_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(DRV_CYC);
  localparam logic [CW-1:0] LAST = CW'(DRV_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          drv_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      drv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (drv_q) begin
        if (cnt_q == '0) begin
          drv_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (start_i) begin
        drv_q <= 1'b1;
        cnt_q <= LAST;
      end
    end
  end

  assign drive_o = drv_q;
  assign done_o  = done_q;
endmodule

// File: rtl/usb_line_mon.sv
module usb_line_mon
  import usb_lsm_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 48_000_000,
  parameter int unsigned RST_MS     = 10,
  parameter bit          DOWNSTREAM = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dp_i,
  input  logic       dm_i,
  input  logic       full_speed_i,
  input  logic       rst_start_i,
  output logic [1:0] line_state_o,
  output logic       idle_o,
  output logic       resume_o,
  output logic       bus_reset_o,
  output logic       connect_o,
  output logic       disconnect_o,
  output logic       attached_o,
  output logic       drive_se0_o,
  output logic       drive_done_o
);
  // 2.5 us rounded up to whole cycles
  localparam longint unsigned THR_L = (longint'(CLK_HZ) * 25 + 64'd9_999_999) / 64'd10_000_000;
  localparam longint unsigned RST_L = longint'(CLK_HZ) / 1000 * longint'(RST_MS);
  localparam int unsigned THR_CYC = int'(THR_L);
  localparam int unsigned RST_CYC = int'(RST_L);

  line_e st;
  logic  held;

  usb_lsm_classify i_classify (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dp_i         (dp_i),
    .dm_i         (dm_i),
    .full_speed_i (full_speed_i),
    .state_o      (st)
  );

  usb_lsm_timer #(.CNT_MAX(THR_CYC)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (st),
    .held_o  (held)
  );

  usb_lsm_events i_events (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_i      (st),
    .held_i       (held),
    .idle_o       (idle_o),
    .resume_o     (resume_o),
    .bus_reset_o  (bus_reset_o),
    .connect_o    (connect_o),
    .disconnect_o (disconnect_o),
    .attached_o   (attached_o)
  );

  generate
    if (DOWNSTREAM) begin : g_drv
      usb_lsm_rstdrv #(.DRV_CYC(RST_CYC)) i_rstdrv (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (rst_start_i),
        .drive_o (drive_se0_o),
        .done_o  (drive_done_o)
      );
    end else begin : g_nodrv
      assign drive_se0_o  = 1'b0;
      assign drive_done_o = 1'b0;
    end
  endgenerate

  assign line_state_o = st;
endmodule

// File: rtl/usb_line_mon_chk.sv
module usb_line_mon_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rst_start_i,
  input logic [1:0] line_state_o,
  input logic       resume_o,
  input logic       bus_reset_o,
  input logic       connect_o,
  input logic       disconnect_o,
  input logic       attached_o,
  input logic       drive_se0_o,
  input logic       drive_done_o
);
  // R3
  conn_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    connect_o |=> !connect_o);
  // R3
  att_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(attached_o) |-> connect_o);
  // R4
  att_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(attached_o) |-> disconnect_o);
  // R4
  evt_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(connect_o && disconnect_o));
  // R6
  rst_se0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_o |-> line_state_o == 2'b00);
  // R7
  resume_k_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> line_state_o == 2'b10);
  // R10
  drv_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_se0_o) |-> $past(rst_start_i));
  // R10
  drv_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drive_se0_o) |-> drive_done_o);
endmodule

bind usb_line_mon usb_line_mon_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rst_start_i  (rst_start_i),
  .line_state_o (line_state_o),
  .resume_o     (resume_o),
  .bus_reset_o  (bus_reset_o),
  .connect_o    (connect_o),
  .disconnect_o (disconnect_o),
  .attached_o   (attached_o),
  .drive_se0_o  (drive_se0_o),
  .drive_done_o (drive_done_o)
);

// File: tb/test_usb_line_mon.sv
module test_usb_line_mon;
  localparam int unsigned CLK_HZ  = 4_000_000;
  localparam int unsigned RST_MS  = 10;
  localparam time         T_CLK   = 250ns;
  localparam int          THR     = 10;
  localparam int          RST_CYC = 40000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic dp = 1'b1, dm = 1'b0, fs = 1'b1, start = 1'b0;
  logic [1:0] line_state;
  logic idle, resume, bus_reset, connect, disconnect, attached, drive, done;

  int checks = 0, errors = 0;
  int exp_q[$];

  always #(T_CLK / 2) clk = ~clk;

  usb_line_mon #(.CLK_HZ(CLK_HZ), .RST_MS(RST_MS), .DOWNSTREAM(1'b1)) i_usb_line_mon (
    .clk_i(clk), .rst_ni(rst_ni), .dp_i(dp), .dm_i(dm), .full_speed_i(fs),
    .rst_start_i(start), .line_state_o(line_state), .idle_o(idle), .resume_o(resume),
    .bus_reset_o(bus_reset), .connect_o(connect), .disconnect_o(disconnect),
    .attached_o(attached), .drive_se0_o(drive), .drive_done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lines(input logic p, input logic m);
    dp = p;
    dm = m;
  endtask

  // driver side of the scoreboard: 1 = connect, 2 = disconnect
  task automatic expect_evt(input int k);
    exp_q.push_back(k);
  endtask

  // monitor side
  always @(negedge clk) begin : mon
    int got, e;
    if (rst_ni && (connect || disconnect)) begin
      got = connect ? 1 : 2;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected event act=%0d exp=0", got);
      end else begin
        e = exp_q.pop_front();
        if (e != got) begin
          errors++;
          $display("FAIL R3/R4 event kind act=%0d exp=%0d", got, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=1 exp=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int n;
    cyc(3);
    // R12
    chk("R12 line_state", line_state, 0);
    chk("R12 attached", attached, 0);
    chk("R12 drive", drive, 0);
    chk("R12 events", connect | disconnect | done, 0);
    rst_ni = 1'b1;
    // full-speed J
    cyc(1);
    chk("R1 fs J", line_state, 1);
    expect_evt(1);
    cyc(6);
    chk("R2 idle early", idle, 0);
    chk("R2 attached early", attached, 0);
    cyc(9);
    chk("R3 idle", idle, 1);
    chk("R3 attached", attached, 1);
    // full-speed K
    lines(1'b0, 1'b1);
    cyc(1);
    chk("R1 fs K", line_state, 2);
    chk("R7 resume early", resume, 0);
    cyc(16);
    chk("R7 resume", resume, 1);
    chk("R7 idle low", idle, 0);
    // J again while attached
    lines(1'b1, 1'b0);
    cyc(17);
    chk("R5 idle again", idle, 1);
    chk("R5 attached", attached, 1);
    // SE0 broken by one illegal cycle
    lines(1'b0, 1'b0);
    cyc(8);
    lines(1'b1, 1'b1);
    cyc(1);
    lines(1'b0, 1'b0);
    chk("R1 illegal", line_state, 3);
    expect_evt(2);
    cyc(8);
    chk("R8 no reset after restart", bus_reset, 0);
    chk("R8 still attached", attached, 1);
    cyc(10);
    chk("R6 bus_reset", bus_reset, 1);
    chk("R4 detached", attached, 0);
    lines(1'b1, 1'b0);
    cyc(1);
    chk("R6 reset drops", bus_reset, 0);
    expect_evt(1);
    cyc(16);
    chk("R3 reattached", attached, 1);
    // speed change under steady lines
    fs = 1'b0;
    cyc(1);
    chk("R9 ls K", line_state, 2);
    chk("R9 idle drops", idle, 0);
    cyc(6);
    chk("R9 resume early", resume, 0);
    cyc(10);
    chk("R9 resume", resume, 1);
    lines(1'b0, 1'b1);
    cyc(1);
    chk("R1 ls J", line_state, 1);
    // downstream reset drive
    start = 1'b1;
    cyc(1);
    start = 1'b0;
    chk("R10 drive on", drive, 1);
    n = 0;
    while (drive && n < 100000) begin
      n++;
      if (n == 100) start = 1'b1;
      cyc(1);
      start = 1'b0;
    end
    chk("R11 drive length", n, RST_CYC);
    chk("R10 done pulse", done, 1);
    cyc(1);
    chk("R10 done once", done, 0);
    chk("R11 no restart", drive, 0);
    cyc(4);
    chk("R3 scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule